// File: doc/BRIEF.md
# Selectable Pulse Burst Generator

This block produces a counted burst of active-low pulses on one output line. A software-free front end supplies a 4-bit count select (1 to 9) and a start request; on the rising edge of the request the block opens an output gate and emits exactly the selected number of pulses, paced by a free-running internal tick derived from the system clock. Each pulse holds the line low for one tick and high for the next.

Progress through the burst is tracked by a ten-stage one-hot ring. Every completed pulse moves the single set bit one stage up, and the gate shuts on the pulse that lands the ring on the selected stage. A re-arm timer then runs for a length taken from an input at the moment the gate shuts; when it expires, a one-cycle clear returns the ring to its idle stage and the block reports ready again. Requests that arrive while the block is not ready, or that carry an out-of-range count, have no effect.

Top module: `burst_pulse_gen`

## Requirements
- R1: After an accepted start with `count_sel` = N (binary, 1 to 9), `pulse_n` shows exactly N falling edges before `ready` returns high.
- R2: `pulse_n` is high whenever no burst is in progress; each pulse is low for exactly TICK_DIV clocks (one tick) and is followed by at least one tick high.
- R3: The tick fires on the clock in which a free-running counter, cleared by reset, reaches TICK_DIV-1; the first low of a burst begins at the first tick strictly after the clock that accepts the start.
- R4: The internal stage ring is one-hot over ten stages, starts at stage 0, and only ever moves one stage up (after a pulse ends) or back to stage 0 (re-arm clear).
- R5: `ready` is high only while the ring is at stage 0 and `busy` is low; the value of `rearm_len` (L) is taken on the clock where the last pulse ends, and `ready` returns L+1 clocks after that clock.
- R6: A start edge seen while `ready` is low (during pulses or during the re-arm wait) is ignored: the running burst keeps its length and no extra burst follows.
- R7: Start is edge-detected: holding `start` high yields one burst only, and no further burst follows while it stays high.
- R8: `busy` rises on the clock that accepts a start and falls on the clock of the re-arm clear.
- R9: A `count_sel` of 0 or above 9 at the start edge is rejected: no pulse, `busy` stays low, `ready` stays high.
- R10: While reset (`rst_n` low, asynchronous) is applied, `pulse_n` is 1, `busy` is 0 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request, rising edge acts |
| count_sel | input | SEL_W (4) | Number of pulses, 1 to 9 |
| rearm_len | input | DLY_W (8) | Re-arm wait in clocks, taken when the gate shuts |
| pulse_n | output | 1 | Active-low pulse line |
| busy | output | 1 | Burst or re-arm wait in progress |
| ready | output | 1 | Idle at stage 0, new start will be accepted |

## Verification
The bound checker watches, on every cycle, that the stage ring stays one-hot and only steps up by one or clears to stage 0, that the line is low only inside an open gate, that ready never coincides with an open gate or a low line, and that busy and the gate only rise out of the idle state. Exact burst lengths for each select value, the tick-accurate position and width of each pulse, the L+1 clock re-arm delay, and the rejection of held, repeated, early and out-of-range requests can only be shown by the bench's scenarios compared clock by clock against its reference model.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
   // Width needed to hold a value in 0..n-1 (at least one bit).
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bpg_tick_div.sv
module bpg_tick_div #(
   parameter int unsigned TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_every_clock
      assign tick = 1'b1;
   end else begin : g_divider
      localparam int unsigned CW = bpg_pkg::idx_w(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
   end
endmodule

// File: rtl/bpg_stage_ring.sv
module bpg_stage_ring #(
   parameter int unsigned STAGES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              clear,
   output logic [STAGES-1:0] stage
);
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_cell
      if (k == 0) begin : g_home
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stage[k] <= 1'b1;
            else if (clear)   stage[k] <= 1'b1;
            else if (advance) stage[k] <= 1'b0;
         end
      end else begin : g_step
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stage[k] <= 1'b0;
            else if (clear)   stage[k] <= 1'b0;
            else if (advance) stage[k] <= stage[k-1];
         end
      end
   end
endmodule

// File: rtl/bpg_rearm_timer.sv
module bpg_rearm_timer #(
   parameter int unsigned DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] len,
   output logic             fire
);
   if (DLY_W < 1) begin : g_bad_w
      $error("DLY_W must be at least 1");
   end

   logic [DLY_W-1:0] left_q;
   logic             run_q;

   assign fire = run_q && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         run_q  <= 1'b0;
      end else if (load) begin
         left_q <= len;
         run_q  <= 1'b1;
      end else if (fire) begin
         run_q  <= 1'b0;
      end else if (run_q) begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
   parameter int unsigned STAGES   = 10,
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned DLY_W    = 8,
   parameter int unsigned TICK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] count_sel,
   input  logic [DLY_W-1:0] rearm_len,
   output logic             pulse_n,
   output logic             busy,
   output logic             ready
);
   localparam int unsigned MAX_BURST = STAGES - 1;
   localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_BURST);

   if (SEL_W < bpg_pkg::idx_w(STAGES)) begin : g_bad_sel
      $error("SEL_W too narrow for STAGES-1");
   end

   logic              tick;
   logic              start_q;
   logic              gate_q;
   logic              pulse_q;
   logic              busy_q;
   logic [STAGES-1:0] stage;
   logic [STAGES-1:0] target_q;
   logic [STAGES-1:0] sel_dec;
   logic              sel_ok;
   logic              accept;
   logic              drop_low;
   logic              advance;
   logic              shut;
   logic              clear;

   bpg_tick_div #(.TICK_DIV(TICK_DIV)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   bpg_stage_ring #(.STAGES(STAGES)) i_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .clear   (clear),
      .stage   (stage)
   );

   bpg_rearm_timer #(.DLY_W(DLY_W)) i_rearm (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (shut),
      .len   (rearm_len),
      .fire  (clear)
   );

   // One-hot image of the requested stage.
   always_comb begin
      for (int i = 0; i < STAGES; i++) begin
         sel_dec[i] = (count_sel == SEL_W'(i));
      end
   end

   assign sel_ok   = (count_sel != '0) && (count_sel <= MAX_SEL);
   assign ready    = stage[0] && !busy_q;
   assign accept   = start && !start_q && ready && sel_ok;
   assign drop_low = gate_q && tick && pulse_q;
   assign advance  = gate_q && tick && !pulse_q;
   assign shut     = advance && (|((stage << 1) & target_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= 1'b0;
         gate_q   <= 1'b0;
         pulse_q  <= 1'b1;
         busy_q   <= 1'b0;
         target_q <= '0;
      end else begin
         start_q <= start;
         if (accept) begin
            gate_q   <= 1'b1;
            busy_q   <= 1'b1;
            target_q <= sel_dec;
         end
         if (drop_low) pulse_q <= 1'b0;
         if (advance)  pulse_q <= 1'b1;
         if (shut)     gate_q  <= 1'b0;
         if (clear)    busy_q  <= 1'b0;
      end
   end

   assign pulse_n = pulse_q;
   assign busy    = busy_q;
endmodule

// File: rtl/burst_pulse_gen_chk.sv
module burst_pulse_gen_chk #(
   parameter int unsigned STAGES = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pulse_n,
   input logic              busy,
   input logic              ready,
   input logic              gate,
   input logic [STAGES-1:0] stage
);
   a_r4_stage_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(stage));

   a_r4_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stage != $past(stage)) |-> ((stage == ($past(stage) << 1)) || (stage == STAGES'(1))));

   a_r2_low_inside_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_n |-> (gate && busy));

   a_r5_ready_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (pulse_n && !gate));

   a_r8_busy_rise_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ready));

   a_r6_gate_opens_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> ($past(stage[0]) && !$past(busy)));
endmodule

bind burst_pulse_gen burst_pulse_gen_chk #(.STAGES(STAGES)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pulse_n (pulse_n),
   .busy    (busy),
   .ready   (ready),
   .gate    (gate_q),
   .stage   (stage)
);

// File: tb/test_burst_pulse_gen.sv
module test_burst_pulse_gen;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 3;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] count_sel = 4'd0;
   logic [7:0] rearm_len = 8'd0;
   logic       pulse_n, busy, ready;

   int checks = 0;
   int failures = 0;
   int fall_cnt = 0;
   int low_run = 0;
   logic prev_pn = 1'b1;
   int cycles = 0;
   bit done = 0;

   // Reference model state (integers, behavioural)
   int  m_tc, m_done, m_target, m_dly;
   bit  m_start_q, m_gate, m_line, m_busy, m_wait;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_pulse_gen #(.STAGES(10), .SEL_W(4), .DLY_W(8), .TICK_DIV(TICK_DIV)) i_burst_pulse_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .count_sel(count_sel),
      .rearm_len(rearm_len), .pulse_n(pulse_n), .busy(busy), .ready(ready));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model, one step per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_tc = 0; m_done = 0; m_target = 0; m_dly = 0;
         m_start_q = 0; m_gate = 0; m_line = 1; m_busy = 0; m_wait = 0;
      end else begin
         bit tk, edge_seen, rdy;
         tk = (m_tc == TICK_DIV - 1);
         m_tc = tk ? 0 : m_tc + 1;
         edge_seen = start && !m_start_q;
         m_start_q = start;
         rdy = (m_done == 0) && !m_busy;
         if (m_wait) begin
            if (m_dly == 0) begin m_wait = 0; m_done = 0; m_busy = 0; end
            else m_dly--;
         end
         if (m_gate && tk) begin
            if (m_line) m_line = 0;
            else begin
               m_line = 1;
               m_done++;
               if (m_done == m_target) begin
                  m_gate = 0; m_wait = 1; m_dly = int'(rearm_len);
               end
            end
         end
         if (edge_seen && rdy && count_sel >= 1 && count_sel <= 9) begin
            m_gate = 1; m_busy = 1; m_target = int'(count_sel);
         end
      end
   end

   // Per-clock comparison and pulse monitor
   always @(negedge clk) begin
      if (rst_n) begin
         chk(pulse_n == m_line, "R3 pulse_n vs model", pulse_n, m_line);
         chk(busy == m_busy, "R8 busy vs model", busy, m_busy);
         chk(ready == ((m_done == 0) && !m_busy), "R5 ready vs model", ready,
             (m_done == 0) && !m_busy);
         if (prev_pn && !pulse_n) begin fall_cnt++; low_run = 1; end
         else if (!pulse_n) low_run++;
         if (!prev_pn && pulse_n)
            chk(low_run == TICK_DIV, "R2 low width", low_run, TICK_DIV);
         prev_pn = pulse_n;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic wait_ready();
      while (!ready) @(negedge clk);
   endtask

   task automatic burst(input int n, input int len);
      wait_ready();
      count_sel = 4'(n); rearm_len = 8'(len); fall_cnt = 0; start = 1;
      @(negedge clk); start = 0;
      wait_ready();
      chk(fall_cnt == n, "R1 R4 burst length", fall_cnt, n);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(pulse_n == 1'b1, "R10 reset pulse_n", pulse_n, 1);
      chk(busy == 1'b0, "R10 reset busy", busy, 0);
      chk(ready == 1'b1, "R10 reset ready", ready, 1);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1: every legal length, varied re-arm waits (R5)
      for (int n = 1; n <= 9; n++) burst(n, (n * 7) % 23);
      burst(1, 0);
      burst(9, 255);

      // R9: out-of-range selections
      for (int s = 0; s < 3; s++) begin
         int v;
         v = (s == 0) ? 0 : (s == 1) ? 10 : 15;
         wait_ready();
         count_sel = 4'(v); fall_cnt = 0; start = 1;
         @(negedge clk); start = 0;
         repeat (30) @(negedge clk);
         chk(fall_cnt == 0, "R9 rejected select pulses", fall_cnt, 0);
         chk(busy == 1'b0, "R9 rejected select busy", busy, 0);
         chk(ready == 1'b1, "R9 rejected select ready", ready, 1);
      end

      // R7: held start gives one burst
      wait_ready();
      count_sel = 4'd4; rearm_len = 8'd6; fall_cnt = 0; start = 1;
      @(negedge clk);
      wait_ready();
      repeat (40) @(negedge clk);
      chk(fall_cnt == 4, "R7 held start count", fall_cnt, 4);
      chk(busy == 1'b0, "R7 held start no rerun", busy, 0);
      start = 0;
      @(negedge clk);

      // R6: new edges during pulses are ignored
      wait_ready();
      count_sel = 4'd3; rearm_len = 8'd10; fall_cnt = 0; start = 1;
      repeat (2) @(negedge clk); start = 0;
      repeat (2) @(negedge clk); count_sel = 4'd7; start = 1;
      repeat (2) @(negedge clk); start = 0;
      wait_ready();
      chk(fall_cnt == 3, "R6 restart during pulses", fall_cnt, 3);

      // R6: new edge during the re-arm wait is ignored
      count_sel = 4'd2; rearm_len = 8'd60; fall_cnt = 0; start = 1;
      @(negedge clk); start = 0;
      while (fall_cnt < 2) @(negedge clk);
      repeat (3 * TICK_DIV) @(negedge clk);
      chk(ready == 1'b0, "R6 still waiting", ready, 0);
      count_sel = 4'd5; start = 1;
      @(negedge clk); start = 0;
      wait_ready();
      repeat (30) @(negedge clk);
      chk(fall_cnt == 2, "R6 restart during wait", fall_cnt, 2);
      chk(busy == 1'b0, "R6 no late burst", busy, 0);

      // Back-to-back after re-arm still works
      burst(5, 1);

      finish_run();
   end
endmodule